// File: doc/BRIEF.md
# Per-Instruction Write Completion Tracker

This block belongs to the memory coalescer in front of a GPU L1 data cache. A single store instruction is usually split into several line-sized write requests. The compute unit does not want one reply per request. It wants one reply per instruction, so that it can lower the wait counter of the issuing wavefront. The tracker keeps a small table indexed by the instruction's sequence number and counts the write requests that are still outstanding for each instruction.

The coalesce side reports each write request as it is formed. The cache side returns two kinds of acknowledgement:
- An early acknowledgement only says that a store has reached the L1 controller, so a coalescer slot can be freed.
- A completion acknowledgement says that one request is globally done.

The issue side reports, per instruction, the moment its list of not-yet-coalesced packets empties. That report also gives a flow-control token back to the memory pipeline.

A single response to the compute unit is produced once an instruction has no outstanding requests and no packets left to coalesce. Memory-synchronisation requests pass straight through to the cache side and take no table entry.

Top module: `wct_tracker`

## Requirements
- R1: After reset, `resp_valid_o`, `err_o`, `token_o`, `slot_rel_o` and `sync_valid_o` are 0 and `req_ready_o` is 1.
- R2: The first accepted write request for a sequence number allocates an entry with a count of 1. Each further accepted request for that number adds 1. Each completion acknowledgement for it subtracts 1.
- R3: An entry produces a response only when its count is 0 and its drain report has been seen. A count of 0 without a drain report produces no response. A later drain report then produces the response in the following cycle.
- R4: The response carries the sequence number and the return port of the instruction's first request. Return ports given with later requests of the same instruction are ignored.
- R5: While `resp_valid_o` is 1 and `resp_ready_i` is 0, the response stays valid with unchanged sequence number and port. After the handshake the entry is removed, so a further completion acknowledgement for that number is an error.
- R6: An early acknowledgement produces a one-cycle `slot_rel_o` pulse in the next cycle and leaves every count unchanged.
- R7: A sync request appears on `sync_valid_o` / `sync_seq_o` in the next cycle. It creates no entry, so a completion acknowledgement for its number is an error.
- R8: Every drain report produces a one-cycle `token_o` pulse in the next cycle.
- R9: When all entries are valid, `req_ready_o` is 0 for a sequence number that is not in the table and 1 for one that is.
- R10: An accepted request and a completion acknowledgement for the same instruction in the same cycle leave its count unchanged and produce no response.
- R11: A completion acknowledgement whose number has no valid entry, or whose entry has a count of 0, sets `err_o`. `err_o` stays 1 until reset.
- R12: When several entries become complete in the same cycle, the entry allocated in the lowest-numbered free slot is presented first. The table always allocates the lowest free slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | A write request has been formed |
| req_seq_i | input | 16 | Sequence number of the request's instruction |
| req_port_i | input | 4 | Return port of the requester |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| early_ack_i | input | 1 | Early write acknowledgement from the cache side |
| slot_rel_o | output | 1 | Coalesced-table slot release pulse |
| cmpl_valid_i | input | 1 | Write-complete acknowledgement |
| cmpl_seq_i | input | 16 | Sequence number of the completed request |
| drain_valid_i | input | 1 | Instruction has no uncoalesced packets left |
| drain_seq_i | input | 16 | Sequence number of the drained instruction |
| token_o | output | 1 | Flow-control token returned to the memory pipeline |
| sync_valid_i | input | 1 | Memory-synchronisation request |
| sync_seq_i | input | 16 | Sequence number of the sync request |
| sync_valid_o | output | 1 | Sync request forwarded to the cache side |
| sync_seq_o | output | 16 | Sequence number of the forwarded sync |
| resp_valid_o | output | 1 | Instruction-complete response valid |
| resp_ready_i | input | 1 | Compute unit accepts the response |
| resp_seq_o | output | 16 | Sequence number of the completed instruction |
| resp_port_o | output | 4 | Return port captured from the first request |
| err_o | output | 1 | Sticky acknowledgement error |

## Verification
Instructions are driven with one request, then with three requests carrying different ports, and with the drain report arriving before or after the last completion. These patterns separate counting errors from a missing drain gate and from port overwrite. A cycle that carries a request and an acknowledgement for the same instruction shows whether the count updates net-zero. A cycle that completes two entries at once exposes the presentation order. A filled table, a stalled consumer, pass-through sync and early acknowledgements, and acknowledgements for removed, unknown or zero-count entries cover back-pressure, response holding, the bypass paths and the sticky error.

// File: rtl/wct_pkg.sv
package wct_pkg;

    parameter int WCT_SEQ_W  = 16;
    parameter int WCT_PORT_W = 4;
    parameter int WCT_CNT_W  = 6;

    typedef logic [WCT_SEQ_W-1:0]  seq_t;
    typedef logic [WCT_PORT_W-1:0] port_t;
    typedef logic [WCT_CNT_W-1:0]  cnt_t;

    localparam cnt_t CNT_MAX = '1;

    typedef struct packed {
        logic  vld;
        logic  drained;
        seq_t  seq;
        port_t port;
        cnt_t  cnt;
    } entry_t;

    function automatic cnt_t cnt_step(cnt_t base, logic inc, logic dec);
        cnt_t r;
        r = base;
        if (inc && !dec) r = base + cnt_t'(1);
        if (dec && !inc) r = base - cnt_t'(1);
        return r;
    endfunction

endpackage

// File: rtl/wct_match.sv
module wct_match
    import wct_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] vld,
    input  seq_t [N-1:0] seqs,
    input  seq_t         key,
    output logic [N-1:0] hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = vld[i] && (seqs[i] == key);
    end
endmodule

// File: rtl/wct_first.sv
module wct_first #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/wct_tracker.sv
module wct_tracker
    import wct_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid_i,
    input  seq_t  req_seq_i,
    input  port_t req_port_i,
    output logic  req_ready_o,
    input  logic  early_ack_i,
    output logic  slot_rel_o,
    input  logic  cmpl_valid_i,
    input  seq_t  cmpl_seq_i,
    input  logic  drain_valid_i,
    input  seq_t  drain_seq_i,
    output logic  token_o,
    input  logic  sync_valid_i,
    input  seq_t  sync_seq_i,
    output logic  sync_valid_o,
    output seq_t  sync_seq_o,
    output logic  resp_valid_o,
    input  logic  resp_ready_i,
    output seq_t  resp_seq_o,
    output port_t resp_port_o,
    output logic  err_o
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    entry_t [ENTRIES-1:0] tbl_q, tbl_d;
    logic   [ENTRIES-1:0] vld_vec, free_vec, done_vec, nz_vec, max_vec;
    seq_t   [ENTRIES-1:0] seq_vec;
    logic   [ENTRIES-1:0] req_hit, ack_hit, drn_hit;

    logic          free_any, done_any;
    logic [IW-1:0] free_idx, done_idx, sel_idx;
    logic          hold_q, hold_d;
    logic [IW-1:0] hold_idx_q;
    logic          req_any, req_full_hit, req_fire, resp_fire, ack_bad;
    logic          err_q, slot_q, tok_q, sync_q;
    seq_t          sync_seq_q;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_vec
        assign vld_vec[i]  = tbl_q[i].vld;
        assign seq_vec[i]  = tbl_q[i].seq;
        assign free_vec[i] = !tbl_q[i].vld;
        assign nz_vec[i]   = tbl_q[i].cnt != '0;
        assign max_vec[i]  = tbl_q[i].cnt == CNT_MAX;
        assign done_vec[i] = tbl_q[i].vld && tbl_q[i].drained && !nz_vec[i];
    end

    wct_match #(.N(ENTRIES)) u_req_match (
        .vld(vld_vec), .seqs(seq_vec), .key(req_seq_i), .hit(req_hit));
    wct_match #(.N(ENTRIES)) u_ack_match (
        .vld(vld_vec), .seqs(seq_vec), .key(cmpl_seq_i), .hit(ack_hit));
    wct_match #(.N(ENTRIES)) u_drn_match (
        .vld(vld_vec), .seqs(seq_vec), .key(drain_seq_i), .hit(drn_hit));

    wct_first #(.N(ENTRIES), .IW(IW)) u_free_pick (
        .req(free_vec), .any(free_any), .idx(free_idx));
    wct_first #(.N(ENTRIES), .IW(IW)) u_done_pick (
        .req(done_vec), .any(done_any), .idx(done_idx));

    // admission: existing instruction needs counter headroom, new one a free slot
    assign req_any      = |req_hit;
    assign req_full_hit = |(req_hit & max_vec);
    assign req_ready_o  = req_any ? !req_full_hit : free_any;
    assign req_fire     = req_valid_i && req_ready_o;

    // response selection is frozen once a stalled response is visible
    assign sel_idx      = hold_q ? hold_idx_q : done_idx;
    assign resp_valid_o = hold_q || done_any;
    assign resp_seq_o   = tbl_q[sel_idx].seq;
    assign resp_port_o  = tbl_q[sel_idx].port;
    assign resp_fire    = resp_valid_o && resp_ready_i;
    assign hold_d       = resp_valid_o && !resp_ready_i;

    assign ack_bad = cmpl_valid_i && !(|(ack_hit & nz_vec));

    always_comb begin
        tbl_d = tbl_q;
        for (int i = 0; i < ENTRIES; i++) begin
            logic alloc, inc, dec;
            alloc = req_fire && !req_any && (free_idx == IW'(i));
            inc   = alloc || (req_fire && req_hit[i]);
            dec   = cmpl_valid_i && ack_hit[i] && nz_vec[i];
            if (alloc) begin
                tbl_d[i].vld     = 1'b1;
                tbl_d[i].drained = 1'b0;
                tbl_d[i].seq     = req_seq_i;
                tbl_d[i].port    = req_port_i;
                tbl_d[i].cnt     = cnt_step('0, inc, 1'b0);
            end else begin
                tbl_d[i].cnt = cnt_step(tbl_q[i].cnt, inc, dec);
            end
            if (drain_valid_i && drn_hit[i]) tbl_d[i].drained = 1'b1;
            if (resp_fire && (sel_idx == IW'(i))) tbl_d[i].vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_q      <= '0;
            hold_q     <= 1'b0;
            hold_idx_q <= '0;
            err_q      <= 1'b0;
            slot_q     <= 1'b0;
            tok_q      <= 1'b0;
            sync_q     <= 1'b0;
            sync_seq_q <= '0;
        end else begin
            tbl_q      <= tbl_d;
            hold_q     <= hold_d;
            hold_idx_q <= sel_idx;
            err_q      <= err_q | ack_bad;
            slot_q     <= early_ack_i;
            tok_q      <= drain_valid_i;
            sync_q     <= sync_valid_i;
            sync_seq_q <= sync_seq_i;
        end
    end

    assign err_o        = err_q;
    assign slot_rel_o   = slot_q;
    assign token_o      = tok_q;
    assign sync_valid_o = sync_q;
    assign sync_seq_o   = sync_seq_q;

endmodule

// File: rtl/wct_checker.sv
module wct_checker
    import wct_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  early_ack_i,
    input logic  slot_rel_o,
    input logic  drain_valid_i,
    input logic  token_o,
    input logic  sync_valid_i,
    input seq_t  sync_seq_i,
    input logic  sync_valid_o,
    input seq_t  sync_seq_o,
    input logic  resp_valid_o,
    input logic  resp_ready_i,
    input seq_t  resp_seq_o,
    input port_t resp_port_o,
    input logic  err_o
);
    a_r5_resp_hold: assert property (@(posedge clk) disable iff (rst)
        resp_valid_o && !resp_ready_i |=>
            resp_valid_o && $stable(resp_seq_o) && $stable(resp_port_o));

    a_r6_slot_release: assert property (@(posedge clk) disable iff (rst)
        early_ack_i |=> slot_rel_o);

    a_r8_token_return: assert property (@(posedge clk) disable iff (rst)
        drain_valid_i |=> token_o);

    a_r7_sync_bypass: assert property (@(posedge clk) disable iff (rst)
        sync_valid_i |=> sync_valid_o && (sync_seq_o == $past(sync_seq_i)));

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);
endmodule

bind wct_tracker wct_checker u_wct_checker (
    .clk(clk), .rst(rst),
    .early_ack_i(early_ack_i), .slot_rel_o(slot_rel_o),
    .drain_valid_i(drain_valid_i), .token_o(token_o),
    .sync_valid_i(sync_valid_i), .sync_seq_i(sync_seq_i),
    .sync_valid_o(sync_valid_o), .sync_seq_o(sync_seq_o),
    .resp_valid_o(resp_valid_o), .resp_ready_i(resp_ready_i),
    .resp_seq_o(resp_seq_o), .resp_port_o(resp_port_o),
    .err_o(err_o)
);

// File: tb/tb_wct_tracker.sv
module tb_wct_tracker;
    import wct_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  req_valid_i = 1'b0;
    seq_t  req_seq_i = '0;
    port_t req_port_i = '0;
    logic  req_ready_o;
    logic  early_ack_i = 1'b0;
    logic  slot_rel_o;
    logic  cmpl_valid_i = 1'b0;
    seq_t  cmpl_seq_i = '0;
    logic  drain_valid_i = 1'b0;
    seq_t  drain_seq_i = '0;
    logic  token_o;
    logic  sync_valid_i = 1'b0;
    seq_t  sync_seq_i = '0;
    logic  sync_valid_o;
    seq_t  sync_seq_o;
    logic  resp_valid_o;
    logic  resp_ready_i = 1'b1;
    seq_t  resp_seq_o;
    port_t resp_port_o;
    logic  err_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    wct_tracker #(.ENTRIES(16)) dut (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear();
        req_valid_i = 0; early_ack_i = 0; cmpl_valid_i = 0;
        drain_valid_i = 0; sync_valid_i = 0;
    endtask

    task automatic do_req(input int s, input int p);
        req_valid_i = 1; req_seq_i = seq_t'(s); req_port_i = port_t'(p);
        step(); clear();
    endtask

    task automatic do_ack(input int s);
        cmpl_valid_i = 1; cmpl_seq_i = seq_t'(s);
        step(); clear();
    endtask

    task automatic do_drain(input int s);
        drain_valid_i = 1; drain_seq_i = seq_t'(s);
        step(); clear();
    endtask

    task automatic do_reset();
        clear(); resp_ready_i = 1; rst = 1;
        step(); step();
        rst = 0;
    endtask

    task automatic t_reset();
        chk(resp_valid_o == 0, "R1 resp_valid", resp_valid_o, 0);
        chk(err_o == 0, "R1 err", err_o, 0);
        chk(token_o == 0 && slot_rel_o == 0 && sync_valid_o == 0, "R1 pulses",
            token_o + slot_rel_o + sync_valid_o, 0);
        chk(req_ready_o == 1, "R1 req_ready", req_ready_o, 1);
    endtask

    task automatic t_basic();
        do_req(5, 3); do_req(5, 7); do_req(5, 9);
        do_drain(5);
        do_ack(5);
        chk(resp_valid_o == 0, "R2 early after ack1", resp_valid_o, 0);
        do_ack(5);
        chk(resp_valid_o == 0, "R2 early after ack2", resp_valid_o, 0);
        do_ack(5);
        chk(resp_valid_o == 1, "R2 resp after ack3", resp_valid_o, 1);
        chk(resp_seq_o == 5, "R4 resp seq", resp_seq_o, 5);
        chk(resp_port_o == 3, "R4 first port kept", resp_port_o, 3);
        step();
        chk(resp_valid_o == 0, "R2 single response", resp_valid_o, 0);
    endtask

    task automatic t_drain_late();
        do_req(9, 1);
        do_ack(9);
        chk(resp_valid_o == 0, "R3 no resp before drain", resp_valid_o, 0);
        do_drain(9);
        chk(token_o == 1, "R8 token pulse", token_o, 1);
        chk(resp_valid_o == 1 && resp_seq_o == 9, "R3 resp after drain", resp_seq_o, 9);
        step();
        chk(token_o == 0, "R8 token one cycle", token_o, 0);
        chk(resp_valid_o == 0, "R3 consumed", resp_valid_o, 0);
    endtask

    task automatic t_hold();
        resp_ready_i = 0;
        do_req(12, 2); do_drain(12); do_ack(12);
        chk(resp_valid_o == 1, "R5 valid", resp_valid_o, 1);
        step(); step(); step();
        chk(resp_valid_o == 1 && resp_seq_o == 12 && resp_port_o == 2,
            "R5 held while stalled", resp_seq_o, 12);
        resp_ready_i = 1;
        step();
        chk(resp_valid_o == 0, "R5 removed after handshake", resp_valid_o, 0);
    endtask

    task automatic t_early();
        do_req(20, 4); do_drain(20);
        early_ack_i = 1; step(); clear();
        chk(slot_rel_o == 1, "R6 slot release", slot_rel_o, 1);
        chk(resp_valid_o == 0, "R6 count unchanged", resp_valid_o, 0);
        step();
        chk(slot_rel_o == 0, "R6 one cycle", slot_rel_o, 0);
        do_ack(20);
        chk(resp_valid_o == 1 && resp_seq_o == 20, "R6 needs completion ack", resp_seq_o, 20);
        step();
    endtask

    task automatic t_sync();
        sync_valid_i = 1; sync_seq_i = 16'd33; step(); clear();
        chk(sync_valid_o == 1 && sync_seq_o == 33, "R7 sync forwarded", sync_seq_o, 33);
        chk(resp_valid_o == 0, "R7 no response", resp_valid_o, 0);
    endtask

    task automatic t_same();
        do_req(40, 6);
        req_valid_i = 1; req_seq_i = 16'd40; req_port_i = 4'd6;
        cmpl_valid_i = 1; cmpl_seq_i = 16'd40;
        step(); clear();
        chk(resp_valid_o == 0, "R10 no resp same cycle", resp_valid_o, 0);
        do_drain(40);
        chk(resp_valid_o == 0, "R10 count still one", resp_valid_o, 0);
        do_ack(40);
        chk(resp_valid_o == 1 && resp_seq_o == 40, "R10 final resp", resp_seq_o, 40);
        step();
    endtask

    task automatic t_order();
        do_req(50, 1); do_req(51, 2);
        do_drain(51); do_ack(50);
        drain_valid_i = 1; drain_seq_i = 16'd50;
        cmpl_valid_i = 1; cmpl_seq_i = 16'd51;
        step(); clear();
        chk(resp_valid_o == 1 && resp_seq_o == 50, "R12 lowest slot first", resp_seq_o, 50);
        step();
        chk(resp_valid_o == 1 && resp_seq_o == 51, "R12 second entry", resp_seq_o, 51);
        step();
        chk(resp_valid_o == 0, "R12 drained", resp_valid_o, 0);
    endtask

    task automatic t_full();
        for (int k = 0; k < 16; k++) do_req(100 + k, k);
        req_seq_i = 16'd200; #1;
        chk(req_ready_o == 0, "R9 full blocks new seq", req_ready_o, 0);
        req_seq_i = 16'd105; #1;
        chk(req_ready_o == 1, "R9 full admits known seq", req_ready_o, 1);
        for (int k = 0; k < 16; k++) begin
            do_drain(100 + k);
            do_ack(100 + k);
        end
        step(); step();
        chk(resp_valid_o == 0, "R9 all completed", resp_valid_o, 0);
        chk(req_ready_o == 1, "R9 space again", req_ready_o, 1);
    endtask

    task automatic t_errors();
        chk(err_o == 0, "R11 clean so far", err_o, 0);
        do_ack(12);
        chk(err_o == 1, "R5 ack after removal errors", err_o, 1);
        step(); step();
        chk(err_o == 1, "R11 sticky", err_o, 1);
        do_reset();
        chk(err_o == 0, "R1 err cleared", err_o, 0);
        sync_valid_i = 1; sync_seq_i = 16'd33; step(); clear();
        do_ack(33);
        chk(err_o == 1, "R7 sync made no entry", err_o, 1);
        do_reset();
        do_req(60, 0); do_ack(60);
        chk(err_o == 0, "R11 valid ack ok", err_o, 0);
        do_ack(60);
        chk(err_o == 1, "R11 zero count ack", err_o, 1);
    endtask

    initial begin
        clear();
        step(); step();
        rst = 0;
        t_reset();
        t_basic();
        t_drain_late();
        t_hold();
        t_early();
        t_sync();
        t_same();
        t_order();
        t_full();
        t_errors();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule